// File: doc/BRIEF.md
# Register-Driven Data EEPROM Controller

This block sits between a processor's simple register bus and a small byte-wide non-volatile data array. Software reaches it through five bus registers: a bank selector, an address register, a data register, a control register and an interrupt register. To read a byte, software loads the address, sets the read enable, and then sets the read start bit. To write a byte, software loads the address and data, sets the write enable, and sets the write start bit on the very next bus access. A start bit stays at 1 while its operation runs and returns to 0 when the operation ends, so software can poll it.

A write lasts a programmable number of pulses on a separate timer tick input, which runs apart from the bus clock. The end of each write raises a sticky done flag and a shared multi-function request flag. An interrupt request leaves the block only when every enable and the stack-not-full input allow it. The bus accepts an access in every cycle, with no back-pressure. Read data is a combinational function of the bus address.

Top module: `nvm_regctl`

## Requirements
- R1: After reset the bank selector, address register, data register, every control bit and every interrupt bit read 0, and `irq_o` is 0.
- R2: Control register bits are: bit0 read enable, bit1 read start, bit2 write enable, bit3 write start. A control write with bit1 set starts a read only if read enable was already 1 before that write. Otherwise nothing starts: read start reads back 0 and the data register keeps its value.
- R3: When a read ends, read start returns to 0 and the data register (bus address 2) holds the byte stored at the latched address. It keeps that byte until the next read completes or software writes it.
- R4: A control write with bit3 set starts a write only if write enable was already 1. The byte in the data register is then stored at the address in the address register (bus address 1, low 6 bits).
- R5: Write start is accepted only on the bus access that directly follows the access that wrote write enable as 1. If any other read or write access comes in between, or if write enable was 0 before the access, the request is ignored.
- R6: Write start reads 1 for exactly WR_CYCLES pulses of `tick_i` after acceptance. If no ticks arrive, the write stays in progress.
- R7: Bus address 0 bit0 selects the bank. Address 3 (control) is reachable only while the bank is 1. In bank 0 it reads 0 and writes to it are ignored.
- R8: The end of every write sets the done flag (bit3 of bus address 4) and the multi-function flag (bit4 of bus address 4).
- R9: Bits 0, 1 and 2 of bus address 4 are the global, EEPROM and multi-function enables. `irq_o` is 1 only when all three enables, the multi-function flag and `stack_ok_i` are 1.
- R10: A pulse on `irq_ack_i` clears only the multi-function flag. The done flag stays 1 until software writes it to 0.
- R11: A read or write request made while an operation is in progress is ignored. Writes to the address or data register during a write do not change the write already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | DW | Write data |
| bus_we_i | input | 1 | Write strobe, one access per cycle |
| bus_re_i | input | 1 | Read strobe, counts as an access |
| bus_rdata_o | output | DW | Read data for the addressed register |
| tick_i | input | 1 | Write timer tick |
| stack_ok_i | input | 1 | High when the interrupt stack has room |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default 6-bit address and 8-bit data, and with WR_CYCLES set to 6. With that duration the bench can count the busy window cycle by cycle and still fit many writes into a short run. The full address range is used, including addresses 0 and 63. The bench holds the tick input low for long stretches so that it can write the address and data registers, and issue new requests, while a write is still in flight.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int BUS_AW = 3;

  localparam logic [BUS_AW-1:0] RA_BANK = 3'd0;
  localparam logic [BUS_AW-1:0] RA_ADDR = 3'd1;
  localparam logic [BUS_AW-1:0] RA_DATA = 3'd2;
  localparam logic [BUS_AW-1:0] RA_CTRL = 3'd3;
  localparam logic [BUS_AW-1:0] RA_IRQ  = 3'd4;

  localparam int CB_REN = 0;
  localparam int CB_RGO = 1;
  localparam int CB_WEN = 2;
  localparam int CB_WGO = 3;
  localparam int CTRL_W = 4;

  localparam int IB_GIE  = 0;
  localparam int IB_EIE  = 1;
  localparam int IB_MIE  = 2;
  localparam int IB_DONE = 3;
  localparam int IB_MFF  = 4;
  localparam int IRQ_W   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_RDF  = 2'd2,
    ST_WR   = 2'd3
  } op_state_e;
endpackage

// File: rtl/nvm_wtimer.sv
module nvm_wtimer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(CYCLES);
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done_o = tick_i && (cnt_q == CW'(1));

  // R6
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(cnt_q));

  // R6
  done_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 2 ** AW;

  logic [DW-1:0] cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      cells_q[addr_i] <= wdata_i;
    end
    if (re_i) begin
      rdata_o <= cells_q[addr_i];
    end
  end
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 8,
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wd_i,
  input  logic              access_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              tick_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [DW-1:0]     mem_wd_o,
  output logic              rd_load_o,
  output logic              wr_done_o
);
  op_state_e     state_q;
  logic          ren_q, wen_q, rgo_q, wgo_q, arm_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic          idle, rd_accept, wr_accept, t_done, wr_fin;

  assign idle      = (state_q == ST_IDLE);
  assign rd_accept = ctrl_we_i && ctrl_wd_i[CB_RGO] && ren_q && idle;
  assign wr_accept = ctrl_we_i && ctrl_wd_i[CB_WGO] && wen_q && arm_q && idle && !rd_accept;
  assign wr_fin    = (state_q == ST_WR) && t_done;

  nvm_wtimer #(.CYCLES(WR_CYCLES)) u_wtimer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_accept),
    .tick_i (tick_i),
    .done_o (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ren_q     <= 1'b0;
      wen_q     <= 1'b0;
      rgo_q     <= 1'b0;
      wgo_q     <= 1'b0;
      arm_q     <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        ren_q <= ctrl_wd_i[CB_REN];
        wen_q <= ctrl_wd_i[CB_WEN];
      end
      if (access_i) begin
        arm_q <= ctrl_we_i && ctrl_wd_i[CB_WEN];
      end
      unique case (state_q)
        ST_IDLE: begin
          if (rd_accept) begin
            state_q   <= ST_RD;
            rgo_q     <= 1'b1;
            op_addr_q <= addr_i;
          end else if (wr_accept) begin
            state_q   <= ST_WR;
            wgo_q     <= 1'b1;
            op_addr_q <= addr_i;
            op_data_q <= data_i;
          end
        end
        ST_RD: state_q <= ST_RDF;
        ST_RDF: begin
          state_q <= ST_IDLE;
          rgo_q   <= 1'b0;
        end
        ST_WR: begin
          if (wr_fin) begin
            state_q <= ST_IDLE;
            wgo_q   <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl_o         = '0;
    ctrl_o[CB_REN] = ren_q;
    ctrl_o[CB_RGO] = rgo_q;
    ctrl_o[CB_WEN] = wen_q;
    ctrl_o[CB_WGO] = wgo_q;
  end

  assign mem_we_o   = wr_fin;
  assign mem_re_o   = (state_q == ST_RD);
  assign mem_addr_o = op_addr_q;
  assign mem_wd_o   = op_data_q;
  assign rd_load_o  = (state_q == ST_RDF);
  assign wr_done_o  = wr_fin;

  // R2
  rgo_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rgo_q) |-> $past(ren_q));

  // R4
  wgo_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wgo_q) |-> $past(wen_q));

  // R5
  wgo_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wgo_q) |-> $past(arm_q));

  // R11
  one_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rgo_q && wgo_q));

  // R11
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_WR) && !wr_fin) |=> ($stable(op_addr_q) && $stable(op_data_q)));
endmodule

// File: rtl/nvm_irq.sv
module nvm_irq
  import nvm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_we_i,
  input  logic [IRQ_W-1:0] sw_wd_i,
  input  logic             wr_done_i,
  input  logic             ack_i,
  input  logic             stack_ok_i,
  output logic [IRQ_W-1:0] reg_o,
  output logic             irq_o
);
  logic gie_q, eie_q, mie_q, done_q, mff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      eie_q  <= 1'b0;
      mie_q  <= 1'b0;
      done_q <= 1'b0;
      mff_q  <= 1'b0;
    end else begin
      if (sw_we_i) begin
        gie_q  <= sw_wd_i[IB_GIE];
        eie_q  <= sw_wd_i[IB_EIE];
        mie_q  <= sw_wd_i[IB_MIE];
        done_q <= sw_wd_i[IB_DONE];
        mff_q  <= sw_wd_i[IB_MFF];
      end
      if (ack_i) begin
        mff_q <= 1'b0;
      end
      if (wr_done_i) begin
        done_q <= 1'b1;
        mff_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_o          = '0;
    reg_o[IB_GIE]  = gie_q;
    reg_o[IB_EIE]  = eie_q;
    reg_o[IB_MIE]  = mie_q;
    reg_o[IB_DONE] = done_q;
    reg_o[IB_MFF]  = mff_q;
  end

  assign irq_o = gie_q && eie_q && mie_q && mff_q && stack_ok_i;

  // R8
  flags_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_i |=> (done_q && mff_q));

  // R10
  ack_keeps_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !sw_we_i && !wr_done_i) |=> (!mff_q && (done_q == $past(done_q))));

  // R9
  stack_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stack_ok_i |-> !irq_o);
endmodule

// File: rtl/nvm_regctl.sv
module nvm_regctl
  import nvm_pkg::*;
#(
  parameter int          AW        = 6,
  parameter int          DW        = 8,
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic              tick_i,
  input  logic              stack_ok_i,
  input  logic              irq_ack_i,
  output logic              irq_o
);
  logic              bank_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic              ctrl_we, irq_we, access;
  logic [CTRL_W-1:0] ctrl;
  logic [IRQ_W-1:0]  irq_reg;
  logic              mem_we, mem_re, rd_load, wr_done;
  logic [AW-1:0]     mem_addr;
  logic [DW-1:0]     mem_wd, mem_rd;

  assign access  = bus_we_i || bus_re_i;
  assign ctrl_we = bus_we_i && (bus_addr_i == RA_CTRL) && bank_q;
  assign irq_we  = bus_we_i && (bus_addr_i == RA_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (bus_we_i && (bus_addr_i == RA_BANK)) bank_q <= bus_wdata_i[0];
      if (bus_we_i && (bus_addr_i == RA_ADDR)) addr_q <= bus_wdata_i[AW-1:0];
      if (rd_load) begin
        data_q <= mem_rd;
      end else if (bus_we_i && (bus_addr_i == RA_DATA)) begin
        data_q <= bus_wdata_i;
      end
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      RA_BANK: bus_rdata_o = {{(DW-1){1'b0}}, bank_q};
      RA_ADDR: bus_rdata_o = DW'(addr_q);
      RA_DATA: bus_rdata_o = data_q;
      RA_CTRL: bus_rdata_o = bank_q ? DW'(ctrl) : '0;
      RA_IRQ:  bus_rdata_o = DW'(irq_reg);
      default: bus_rdata_o = '0;
    endcase
  end

  nvm_seq #(.AW(AW), .DW(DW), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (ctrl_we),
    .ctrl_wd_i  (bus_wdata_i[CTRL_W-1:0]),
    .access_i   (access),
    .addr_i     (addr_q),
    .data_i     (data_q),
    .tick_i     (tick_i),
    .ctrl_o     (ctrl),
    .mem_we_o   (mem_we),
    .mem_re_o   (mem_re),
    .mem_addr_o (mem_addr),
    .mem_wd_o   (mem_wd),
    .rd_load_o  (rd_load),
    .wr_done_o  (wr_done)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_array (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .re_i    (mem_re),
    .addr_i  (mem_addr),
    .wdata_i (mem_wd),
    .rdata_o (mem_rd)
  );

  nvm_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_we_i    (irq_we),
    .sw_wd_i    (bus_wdata_i[IRQ_W-1:0]),
    .wr_done_i  (wr_done),
    .ack_i      (irq_ack_i),
    .stack_ok_i (stack_ok_i),
    .reg_o      (irq_reg),
    .irq_o      (irq_o)
  );

  // R7
  bank_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && (bus_addr_i == RA_CTRL) && !bank_q) |=>
      ($stable(ctrl[CB_REN]) && $stable(ctrl[CB_WEN])));

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_load && !(bus_we_i && (bus_addr_i == RA_DATA))) |=> $stable(data_q));
endmodule

// File: tb/test_nvm_regctl.sv
module test_nvm_regctl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int WRC = 6;
  localparam logic [2:0] A_BANK = 3'd0, A_ADDR = 3'd1, A_DATA = 3'd2,
                         A_CTRL = 3'd3, A_IRQ = 3'd4;
  localparam int NV = 4;
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  8'hA5}, {6'd63, 8'h3C}, {6'd21, 8'hFF}, {6'd42, 8'h6E}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0, re = 1'b0;
  logic [7:0] rdata;
  logic       tick = 1'b1, stack_ok = 1'b1, ack = 1'b0;
  logic       irq;
  int         nchk = 0, nerr = 0;

  always #2.5 clk = ~clk;

  nvm_regctl #(.AW(6), .DW(8), .WR_CYCLES(WRC)) i_nvm_regctl (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_we_i(we), .bus_re_i(re), .bus_rdata_o(rdata), .tick_i(tick),
    .stack_ok_i(stack_ok), .irq_ack_i(ack), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; re = 1'b1; #1; d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle(input int bitpos);
    logic [7:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(A_CTRL, v);
      if (!v[bitpos]) break;
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [7:0] d);
    wr(A_ADDR, {2'b00, a});
    wr(A_DATA, d);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h0C);
    wait_idle(3);
  endtask

  task automatic do_read(input logic [5:0] a, output logic [7:0] d);
    wr(A_ADDR, {2'b00, a});
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h03);
    wait_idle(1);
    rd(A_DATA, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_BANK, v); chk("R1 bank", v, 8'h00);
    rd(A_ADDR, v); chk("R1 addr", v, 8'h00);
    rd(A_DATA, v); chk("R1 data", v, 8'h00);
    rd(A_IRQ, v);  chk("R1 irq reg", v, 8'h00);
    chk("R1 irq_o", {7'b0, irq}, 8'h00);
    wr(A_BANK, 8'h01);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);

    // R7 bank gating
    wr(A_BANK, 8'h00);
    wr(A_CTRL, 8'h05);
    wr(A_BANK, 8'h01);
    rd(A_CTRL, v); chk("R7 bank0 write ignored", v, 8'h00);
    wr(A_CTRL, 8'h01);
    wr(A_BANK, 8'h00);
    rd(A_CTRL, v); chk("R7 bank0 reads zero", v, 8'h00);
    wr(A_BANK, 8'h01);
    rd(A_CTRL, v); chk("R7 bank1 reads back", v, 8'h01);

    // R4 R3 table of writes then read-backs
    for (int k = 0; k < NV; k++) do_write(VEC[k][13:8], VEC[k][7:0]);
    for (int k = 0; k < NV; k++) begin
      do_read(VEC[k][13:8], v);
      chk($sformatf("R4 R3 readback %0d", k), v, VEC[k][7:0]);
    end

    // R2 read start without prior enable
    wr(A_CTRL, 8'h00);
    wr(A_ADDR, 8'd0);
    wr(A_CTRL, 8'h03);
    repeat (4) @(negedge clk);
    rd(A_CTRL, v); chk("R2 start ignored", v, 8'h01);
    rd(A_DATA, v); chk("R2 data kept", v, 8'h6E);

    // R3 data holds across address changes
    wr(A_ADDR, 8'd63);
    repeat (3) @(negedge clk);
    rd(A_DATA, v); chk("R3 data holds", v, 8'h6E);

    // R5 intervening access cancels write start
    wr(A_ADDR, 8'd0); wr(A_DATA, 8'h11);
    wr(A_CTRL, 8'h04);
    rd(A_ADDR, v);
    wr(A_CTRL, 8'h0C);
    rd(A_CTRL, v); chk("R5 intervening access", v, 8'h04);
    do_read(6'd0, v); chk("R5 cell unchanged", v, 8'hA5);
    // R4 enable and start in the same access
    wr(A_ADDR, 8'd0); wr(A_DATA, 8'h22);
    wr(A_CTRL, 8'h0C);
    rd(A_CTRL, v); chk("R4 start without prior enable", v, 8'h04);
    do_read(6'd0, v); chk("R4 cell unchanged", v, 8'hA5);

    // R6 exact duration with a tick every cycle
    wr(A_ADDR, 8'd21); wr(A_DATA, 8'h81);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h0C);
    addr = A_CTRL; cnt = 0;
    for (int i = 0; i < 50; i++) begin
      #1;
      if (rdata[3]) cnt++; else break;
      @(negedge clk);
    end
    chk("R6 busy cycles", 8'(cnt), 8'(WRC));
    do_read(6'd21, v); chk("R6 R4 written", v, 8'h81);

    // R6 no ticks keeps write pending; R11 busy behaviour
    tick = 1'b0;
    wr(A_ADDR, 8'd5); wr(A_DATA, 8'h5A);
    wr(A_CTRL, 8'h04);
    wr(A_CTRL, 8'h0C);
    repeat (30) @(negedge clk);
    rd(A_CTRL, v); chk("R6 held without ticks", {7'b0, v[3]}, 8'h01);
    wr(A_ADDR, 8'd63); wr(A_DATA, 8'h99);
    wr(A_CTRL, 8'h01);
    wr(A_CTRL, 8'h03);
    rd(A_CTRL, v); chk("R11 read start ignored while busy", v, 8'h09);
    tick = 1'b1;
    wait_idle(3);
    do_read(6'd5, v);  chk("R11 in-flight write kept", v, 8'h5A);
    do_read(6'd63, v); chk("R11 other cell untouched", v, 8'h3C);

    // R8 R9 R10 flags and interrupt
    wr(A_IRQ, 8'h00);
    do_write(6'd42, 8'h77);
    rd(A_IRQ, v); chk("R8 flags set", v, 8'h18);
    chk("R9 no enables", {7'b0, irq}, 8'h00);
    wr(A_IRQ, 8'h1E);
    #1; chk("R9 global off", {7'b0, irq}, 8'h00);
    wr(A_IRQ, 8'h1F);
    #1; chk("R9 all enabled", {7'b0, irq}, 8'h01);
    stack_ok = 1'b0; #1;
    chk("R9 stack full", {7'b0, irq}, 8'h00);
    stack_ok = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk("R10 irq after ack", {7'b0, irq}, 8'h00);
    rd(A_IRQ, v); chk("R10 only mf flag cleared", v, 8'h0F);
    wr(A_IRQ, 8'h07);
    rd(A_IRQ, v); chk("R10 done cleared by software", v, 8'h07);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule